// File: doc/BRIEF.md
# Timer Input Capture and Event Flag Unit

This block sits beside a timer's counter and records when things happen to it. Up to four capture channels watch four input lines. When a channel is switched on and one of its watched lines changes level, in either direction, the channel copies the counter value into its own capture register. In the same cycle it raises a capture flag. A separate update pulse from the counter, which marks an overflow or underflow, raises an update flag in the same status word.

Software reaches the unit through a small register port. The status word is cleared by writing zeros: a one leaves a flag alone, so a handler clears exactly the flags it serviced with one write. An interrupt-enable word masks the flags onto a single registered interrupt line. Each channel has an enable bit and a 2-bit mode field, and both must be set for the channel to capture. A per-channel input-select field can steer a channel onto a neighbouring input line. Channels that are not built read their enable bits back as zero, so software can count the channels by writing ones and reading them back.

Top module: `tcf_capture_unit`

## Requirements
- R1: After synchronous reset every register reads 0 and `irq` is 0.
- R2: A channel captures when its enable bit is 1 and its mode field is 01. It captures at the clock edge where its selected input is first sampled at a level different from the previous sample, on both rising and falling changes. The capture register takes the `cnt_val` present at that edge.
- R3: A capture flag (status bit 1+n for channel n) is set at the same edge as its capture register loads. If a write-0 clear of that flag happens at the same edge, the flag stays set.
- R4: Writing the status word (address 2) clears each flag whose written bit is 0. Written bits of 1 leave the flags unchanged.
- R5: A high `upd_pulse` sets status bit 0 at that edge, and this set wins over a coincident write-0 clear.
- R6: `irq` goes high one cycle after some status bit and its interrupt-enable bit (address 1: bit 0 update, bit 1+n channel n) are both 1, and goes low one cycle after no such pair remains.
- R7: For channels at or above NUM_CH, the enable, mode, select, interrupt-enable and flag bits read 0. The capture register of such a channel reads 0 whatever its input does.
- R8: A channel whose enable bit is 0, or whose mode field is not 01, does not capture. Its capture register and its flag keep their values.
- R9: The input-select field of channel n (address 3, bits 2n+1:2n) has a value s that makes the channel watch input (n+s) mod 4, and the reset value 0 watches input n. Changing the select does not by itself cause a capture.
- R10: Capture registers (addresses 4+n) are read-only: writes to them have no effect.
- R11: The channel control word is at address 0. Its enable bits are 3:0 and the mode of channel n is in bits 9+2n:8+2n. Read data is registered: `reg_rdata` shows the register selected by `reg_addr` at one edge from that edge on, and a write takes effect at the edge where `reg_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Current counter value to capture |
| cap_in | input | 4 | Channel input lines, already synchronised and filtered |
| upd_pulse | input | 1 | Counter overflow/underflow pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the unit with NUM_CH=3, CNT_W=16 and DATA_W=32. The fourth channel is then absent while its input line and its select field still exist, so the bench can check that its enable, interrupt-enable and flag bits stay 0 and that its capture register stays 0. It can also steer a built channel onto a neighbour's input. The 16-bit counter inside a 32-bit read word lets every capture read also check that the upper bits are zero.

// File: rtl/tcf_pkg.sv
`timescale 1ns/1ps
package tcf_pkg;
  localparam int MAX_CH   = 4;
  localparam int STAT_W   = MAX_CH + 1;
  localparam int MODE_W   = 2;
  localparam int SEL_W    = 2;
  localparam int ADDR_W   = 3;
  localparam int MODE_LSB = 8;
  localparam int CTL_W    = MODE_LSB + MODE_W * MAX_CH;
  localparam int INSEL_W  = SEL_W * MAX_CH;

  typedef enum logic [ADDR_W-1:0] {
    RA_CHCTL = 3'd0,
    RA_IEN   = 3'd1,
    RA_STAT  = 3'd2,
    RA_INSEL = 3'd3,
    RA_CAP0  = 3'd4,
    RA_CAP1  = 3'd5,
    RA_CAP2  = 3'd6,
    RA_CAP3  = 3'd7
  } reg_addr_e;

  localparam logic [MODE_W-1:0] MODE_OFF        = 2'b00;
  localparam logic [MODE_W-1:0] MODE_CAP_DIRECT = 2'b01;

  function automatic logic [MAX_CH-1:0] impl_mask(input int n);
    logic [MAX_CH-1:0] m;
    for (int i = 0; i < MAX_CH; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/tcf_edge_detect.sv
`timescale 1ns/1ps
module tcf_edge_detect #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sig_in,
  output logic [N-1:0] toggled
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sig_in;
  end

  assign toggled = sig_in ^ prev_q;
endmodule

// File: rtl/tcf_cap_channel.sv
`timescale 1ns/1ps
module tcf_cap_channel
  import tcf_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int IDX   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [MODE_W-1:0] mode,
  input  logic [SEL_W-1:0]  sel,
  input  logic [MAX_CH-1:0] toggled,
  input  logic [CNT_W-1:0]  cnt,
  output logic              hit,
  output logic [CNT_W-1:0]  cap_q
);
  logic [SEL_W-1:0] src;

  assign src = SEL_W'(IDX) + sel;
  assign hit = enable && (mode == MODE_CAP_DIRECT) && toggled[src];

  always_ff @(posedge clk) begin
    if (rst)      cap_q <= '0;
    else if (hit) cap_q <= cnt;
  end
endmodule

// File: rtl/tcf_ctrl_regs.sv
`timescale 1ns/1ps
module tcf_ctrl_regs
  import tcf_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_chctl,
  input  logic                      wr_insel,
  input  logic [CTL_W-1:0]          wdata,
  output logic [MAX_CH-1:0]         ch_en,
  output logic [MODE_W*MAX_CH-1:0]  ch_mode,
  output logic [SEL_W*MAX_CH-1:0]   ch_sel,
  output logic [CTL_W-1:0]          chctl_rd,
  output logic [INSEL_W-1:0]        insel_rd
);
  logic unused_wdata;
  assign unused_wdata = ^wdata;

  for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
    if (c < NUM_CH) begin : g_on
      logic              en_r;
      logic [MODE_W-1:0] mode_r;
      logic [SEL_W-1:0]  sel_r;

      always_ff @(posedge clk) begin
        if (rst) begin
          en_r   <= 1'b0;
          mode_r <= MODE_OFF;
          sel_r  <= '0;
        end else begin
          if (wr_chctl) begin
            en_r   <= wdata[c];
            mode_r <= wdata[MODE_LSB + MODE_W*c +: MODE_W];
          end
          if (wr_insel) sel_r <= wdata[SEL_W*c +: SEL_W];
        end
      end

      assign ch_en[c]                  = en_r;
      assign ch_mode[MODE_W*c +: MODE_W] = mode_r;
      assign ch_sel[SEL_W*c +: SEL_W]    = sel_r;
    end else begin : g_off
      assign ch_en[c]                  = 1'b0;
      assign ch_mode[MODE_W*c +: MODE_W] = MODE_OFF;
      assign ch_sel[SEL_W*c +: SEL_W]    = '0;
    end
  end

  assign chctl_rd = {ch_mode, {(MODE_LSB-MAX_CH){1'b0}}, ch_en};
  assign insel_rd = ch_sel;
endmodule

// File: rtl/tcf_flags.sv
`timescale 1ns/1ps
module tcf_flags
  import tcf_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stat,
  input  logic              wr_ien,
  input  logic [STAT_W-1:0] wdata,
  input  logic              upd_pulse,
  input  logic [MAX_CH-1:0] cap_hit,
  output logic [STAT_W-1:0] status_q,
  output logic [STAT_W-1:0] ien_q,
  output logic              irq
);
  localparam logic [STAT_W-1:0] IMPL = {impl_mask(NUM_CH), 1'b1};

  logic [STAT_W-1:0] kept;
  logic [STAT_W-1:0] set_v;

  assign kept  = wr_stat ? (status_q & wdata) : status_q;
  assign set_v = {cap_hit, upd_pulse};

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      ien_q    <= '0;
      irq      <= 1'b0;
    end else begin
      status_q <= (kept | set_v) & IMPL;
      if (wr_ien) ien_q <= wdata & IMPL;
      irq <= |(status_q & ien_q);
    end
  end
endmodule

// File: rtl/tcf_capture_unit.sv
`timescale 1ns/1ps
module tcf_capture_unit
  import tcf_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic [MAX_CH-1:0] cap_in,
  input  logic              upd_pulse,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [MAX_CH-1:0]        toggled;
  logic [MAX_CH-1:0]        ch_en;
  logic [MODE_W*MAX_CH-1:0] ch_mode;
  logic [SEL_W*MAX_CH-1:0]  ch_sel;
  logic [CTL_W-1:0]         chctl_rd;
  logic [INSEL_W-1:0]       insel_rd;
  logic [STAT_W-1:0]        status_q;
  logic [STAT_W-1:0]        ien_q;
  logic [MAX_CH-1:0]        cap_hit;
  logic [CNT_W-1:0]         cap_arr [MAX_CH];
  logic [CNT_W*MAX_CH-1:0]  cap_flat;
  logic [DATA_W-1:0]        rd_next;
  logic                     wr_chctl, wr_insel, wr_stat, wr_ien;
  logic                     unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign wr_chctl = reg_wr && (reg_addr == RA_CHCTL);
  assign wr_insel = reg_wr && (reg_addr == RA_INSEL);
  assign wr_stat  = reg_wr && (reg_addr == RA_STAT);
  assign wr_ien   = reg_wr && (reg_addr == RA_IEN);

  tcf_edge_detect #(.N(MAX_CH)) u_edge (
    .clk(clk), .rst(rst), .sig_in(cap_in), .toggled(toggled)
  );

  tcf_ctrl_regs #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst(rst), .wr_chctl(wr_chctl), .wr_insel(wr_insel),
    .wdata(reg_wdata[CTL_W-1:0]), .ch_en(ch_en), .ch_mode(ch_mode),
    .ch_sel(ch_sel), .chctl_rd(chctl_rd), .insel_rd(insel_rd)
  );

  for (genvar c = 0; c < MAX_CH; c++) begin : g_cap
    if (c < NUM_CH) begin : g_on
      tcf_cap_channel #(.CNT_W(CNT_W), .IDX(c)) u_chan (
        .clk(clk), .rst(rst), .enable(ch_en[c]),
        .mode(ch_mode[MODE_W*c +: MODE_W]), .sel(ch_sel[SEL_W*c +: SEL_W]),
        .toggled(toggled), .cnt(cnt_val), .hit(cap_hit[c]),
        .cap_q(cap_arr[c])
      );
    end else begin : g_off
      logic unused_ch;
      assign unused_ch  = ch_en[c] ^ (^ch_mode[MODE_W*c +: MODE_W]) ^ (^ch_sel[SEL_W*c +: SEL_W]);
      assign cap_hit[c] = 1'b0;
      assign cap_arr[c] = '0;
    end
    assign cap_flat[CNT_W*c +: CNT_W] = cap_arr[c];
  end

  tcf_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk(clk), .rst(rst), .wr_stat(wr_stat), .wr_ien(wr_ien),
    .wdata(reg_wdata[STAT_W-1:0]), .upd_pulse(upd_pulse), .cap_hit(cap_hit),
    .status_q(status_q), .ien_q(ien_q), .irq(irq)
  );

  always_comb begin
    case (reg_addr)
      RA_CHCTL: rd_next = DATA_W'(chctl_rd);
      RA_IEN:   rd_next = DATA_W'(ien_q);
      RA_STAT:  rd_next = DATA_W'(status_q);
      RA_INSEL: rd_next = DATA_W'(insel_rd);
      default:  rd_next = DATA_W'(cap_arr[reg_addr[1:0]]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/tcf_checker.sv
`timescale 1ns/1ps
module tcf_checker
  import tcf_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     reg_wr,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic [STAT_W-1:0]        wdata_lo,
  input logic                     upd_pulse,
  input logic [CNT_W-1:0]         cnt_val,
  input logic                     irq,
  input logic [STAT_W-1:0]        status_q,
  input logic [STAT_W-1:0]        ien_q,
  input logic [MAX_CH-1:0]        cap_hit,
  input logic [MAX_CH-1:0]        ch_en,
  input logic [CNT_W*MAX_CH-1:0]  cap_flat
);
  localparam logic [STAT_W-1:0] IMPL = {impl_mask(NUM_CH), 1'b1};

  logic [STAT_W-1:0] clr_mask;
  logic [STAT_W-1:0] held;
  assign clr_mask = (reg_wr && reg_addr == RA_STAT) ? ~wdata_lo : '0;
  assign held     = status_q & ~clr_mask;

  // R3: capture flags rise with the capture
  assert_capflag_R3: assert property (@(posedge clk) disable iff (rst)
    (|cap_hit) |=> ((status_q[STAT_W-1:1] & $past(cap_hit)) == $past(cap_hit)));

  // R5: update pulse always sets bit 0
  assert_updflag_R5: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |=> status_q[0]);

  // R4: a flag only falls where a zero was written
  assert_w0clr_R4: assert property (@(posedge clk) disable iff (rst)
    (held != '0) |=> ((status_q & $past(held)) == $past(held)));

  // R6: enabled pending flag raises irq
  assert_irq_R6: assert property (@(posedge clk) disable iff (rst)
    (|(status_q & ien_q)) |=> irq);

  // R7: absent channels never flag or enable
  assert_noimpl_R7: assert property (@(posedge clk) disable iff (rst)
    (((status_q | ien_q) & ~IMPL) == '0));

  for (genvar c = 0; c < MAX_CH; c++) begin : g_chk
    if (c < NUM_CH) begin : g_on
      // R2: capture loads the counter value
      assert_capload_R2: assert property (@(posedge clk) disable iff (rst)
        cap_hit[c] |=> (cap_flat[CNT_W*c +: CNT_W] == $past(cnt_val)));
      // R8: no capture keeps the register
      assert_caphold_R8: assert property (@(posedge clk) disable iff (rst)
        !cap_hit[c] |=> $stable(cap_flat[CNT_W*c +: CNT_W]));
      // R8: only enabled channels capture
      assert_hit_en_R8: assert property (@(posedge clk) disable iff (rst)
        cap_hit[c] |-> ch_en[c]);
    end
  end
endmodule

bind tcf_capture_unit tcf_checker #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wdata_lo(reg_wdata[tcf_pkg::STAT_W-1:0]), .upd_pulse(upd_pulse),
  .cnt_val(cnt_val), .irq(irq), .status_q(status_q), .ien_q(ien_q),
  .cap_hit(cap_hit), .ch_en(ch_en), .cap_flat(cap_flat)
);

// File: tb/tcf_capture_unit_tb.sv
`timescale 1ns/1ps
module tcf_capture_unit_tb;
  import tcf_pkg::*;
  localparam int CNT_W  = 16;
  localparam int NUM_CH = 3;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CNT_W-1:0]  cnt_val = '0;
  logic [MAX_CH-1:0] cap_in = '0;
  logic              upd_pulse = 1'b0;
  logic              reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic rd_v = 1'b0;
  logic mon_pend = 1'b0;
  logic [DATA_W-1:0] exp_q [$];
  string tag_q [$];

  always #2.5 clk = ~clk;

  tcf_capture_unit #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .cap_in(cap_in),
    .upd_pulse(upd_pulse), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // monitor: compares each read result against the scoreboard queue
  always @(posedge clk) mon_pend <= rd_v;

  always @(negedge clk) begin
    if (mon_pend && exp_q.size() > 0) begin
      logic [DATA_W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (reg_rdata !== e) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", t, reg_rdata, e);
      end
    end
  end

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string t);
    reg_addr = a;
    rd_v = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_v = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    reg_addr = a;
    reg_wdata = d;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic flip(input int b, input logic [CNT_W-1:0] c);
    cnt_val = c;
    cap_in[b] = ~cap_in[b];
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog: actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(ADDR_W'(a), '0, "R1 reset read");
    chk_irq(1'b0, "R1 reset irq");

    // R11 / R7 control readback
    wr(RA_CHCTL, 32'h0000_550F);
    rd(RA_CHCTL, 32'h0000_1507, "R7 R11 chctl readback");

    // R2 both edges
    flip(0, 16'd100);
    cnt_val = 16'd200;
    rd(RA_CAP0, 32'd100, "R2 rising capture");
    rd(RA_STAT, 32'h2, "R3 flag set");
    flip(0, 16'd300);
    rd(RA_CAP0, 32'd300, "R2 falling capture");

    // R4 write-0 clear
    wr(RA_STAT, 32'hFFFF_FFFF);
    rd(RA_STAT, 32'h2, "R4 write ones keep");
    wr(RA_STAT, 32'hFFFF_FFFD);
    rd(RA_STAT, 32'h0, "R4 write zero clears");

    // R5 / R6 update flag and irq
    upd_pulse = 1'b1;
    @(negedge clk);
    upd_pulse = 1'b0;
    rd(RA_STAT, 32'h1, "R5 update flag");
    chk_irq(1'b0, "R6 masked irq");
    wr(RA_IEN, 32'hFFFF_FFFF);
    chk_irq(1'b0, "R6 irq latency");
    @(negedge clk);
    chk_irq(1'b1, "R6 irq high");
    rd(RA_IEN, 32'h0000_000F, "R7 ien mask");
    wr(RA_STAT, 32'hFFFF_FFFE);
    chk_irq(1'b1, "R6 irq fall latency");
    @(negedge clk);
    chk_irq(1'b0, "R6 irq low");

    // R3 capture beats coincident clear
    flip(1, 16'd410);
    rd(RA_CAP1, 32'd410, "R2 ch1 capture");
    reg_addr = RA_STAT;
    reg_wdata = '0;
    reg_wr = 1'b1;
    cnt_val = 16'd555;
    cap_in[1] = 1'b0;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(RA_STAT, 32'h4, "R3 capture wins over clear");
    rd(RA_CAP1, 32'd555, "R3 coincident capture value");
    // R5 update beats coincident clear
    reg_addr = RA_STAT;
    reg_wdata = '0;
    reg_wr = 1'b1;
    upd_pulse = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    upd_pulse = 1'b0;
    rd(RA_STAT, 32'h1, "R5 update wins over clear");
    wr(RA_STAT, 32'h0);

    // R8 mode off / enable off
    wr(RA_CHCTL, 32'h0000_0507);
    rd(RA_CHCTL, 32'h0000_0507, "R11 mode field readback");
    flip(2, 16'd777);
    rd(RA_CAP2, 32'd0, "R8 mode off no capture");
    rd(RA_STAT, 32'h0, "R8 mode off no flag");
    wr(RA_CHCTL, 32'h0000_1506);
    flip(0, 16'd888);
    rd(RA_CAP0, 32'd300, "R8 enable off holds");
    rd(RA_STAT, 32'h0, "R8 enable off no flag");

    // R9 input select
    wr(RA_CHCTL, 32'h0000_1507);
    wr(RA_INSEL, 32'h0000_00C4);
    rd(RA_INSEL, 32'h0000_0004, "R9 R7 insel readback");
    rd(RA_STAT, 32'h0, "R9 select change no capture");
    flip(2, 16'd999);
    rd(RA_CAP1, 32'd999, "R9 ch1 follows input 2");
    rd(RA_CAP2, 32'd999, "R9 ch2 own input");
    rd(RA_STAT, 32'hC, "R9 both flags");
    flip(1, 16'd1234);
    rd(RA_CAP1, 32'd999, "R9 ch1 ignores input 1");
    rd(RA_STAT, 32'hC, "R9 no extra flag");
    chk_irq(1'b1, "R6 capture irq");

    // R10 read-only capture registers
    wr(RA_CAP0, 32'h0000_ABCD);
    rd(RA_CAP0, 32'd300, "R10 capture read-only");

    // R7 absent channel
    wr(RA_STAT, 32'h0);
    wr(RA_INSEL, 32'h0);
    flip(3, 16'd4321);
    rd(RA_CAP3, 32'd0, "R7 absent capture zero");
    rd(RA_STAT, 32'h0, "R7 absent flag zero");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule